// File: doc/BRIEF.md
# Processor Interrupt Entry Sequencer

This block handles the interrupt path of a small 8-bit processor core: how an interrupt is taken and how the service routine returns. An external device raises a request. The sequencer looks at that request only when the core reports an instruction boundary, so the instruction in flight always finishes first. A request is taken only when the interrupt-inhibit status bit is clear.

When a request is taken, the sequencer does the following:

- It saves the address of the next instruction on a small internal return stack. Nothing else is saved.
- It sets the inhibit bit.
- It raises acknowledge for one cycle. During that cycle the interrupting device places a vector byte on the data bus.
- It treats that byte as the offset of a branch-to-subroutine relative to address zero, and hands the resulting target to the program counter.

Two return strobes pop the stack and load the saved address. The first return also clears the inhibit bit. The second leaves the bit as it is. A separate write strobe lets software set or clear the inhibit bit directly. This allows nested or repeated entries without popping the stack.

Top module: `irq_entry_seq`

## Requirements
- R1: After a synchronous reset, acknowledge, inhibit and program-counter load are low, the program counter output is zero, and the return stack is empty (its pointer is at entry 0).
- R2: A request is accepted only on a clock edge where the boundary strobe and the request are both high and inhibit is low. A request without the boundary strobe, or a boundary strobe without a request, starts nothing.
- R3: While inhibit is high, requests at a boundary are ignored. No acknowledge is given and the stack is not changed.
- R4: On acceptance, inhibit goes high one cycle after the accepting edge. Acknowledge goes high one cycle later than inhibit and stays high for exactly one cycle.
- R5: The data bus is sampled at the edge that ends the acknowledge cycle. In the next cycle the program-counter load pulses for one cycle, and the program counter equals bus bits 6:0 sign-extended to the address width. Bus bit 7 has no effect. For example, 0x03 gives 0x0003, and 0x40 gives 0x7FC0 with 15-bit addresses.
- R6: The address on the current-address input at the accepting edge is the value pushed. Only that one value is saved.
- R7: The enabling return pops the stack. One cycle later the load pulses with the popped address, and inhibit is low.
- R8: The plain return pops the stack and loads the popped address in the same way, but leaves inhibit unchanged.
- R9: The stack is last-in first-out, 8 entries deep, with a 3-bit pointer. A ninth push wraps and overwrites the oldest entry. A pop from the empty pointer position wraps to entry 7.
- R10: When idle, the strobes are served in this priority order: a return first, then an inhibit write, then a request. While an entry sequence is in progress, returns, inhibit writes and requests are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | High in the last cycle of an instruction |
| irq_i | input | 1 | Interrupt request from the device |
| inh_wr_i | input | 1 | Write strobe for the inhibit bit |
| inh_val_i | input | 1 | Value written to the inhibit bit |
| ret_en_i | input | 1 | Return that re-enables interrupts |
| ret_plain_i | input | 1 | Return that keeps the inhibit bit |
| cur_addr_i | input | AW | Address of the next instruction |
| bus_i | input | DW | Data bus carrying the vector byte |
| ack_o | output | 1 | Interrupt acknowledge |
| inhibit_o | output | 1 | Interrupt-inhibit status bit |
| pc_load_o | output | 1 | One-cycle strobe: load the program counter |
| pc_o | output | AW | New program counter value |

## Verification
The request is tried in several isolated forms: without the boundary strobe, as a boundary without a request, and while inhibit is high. This separates sampling at the boundary from the inhibit gate. Vector bytes are chosen as follows:

- a small positive value;
- a value with bit 6 set;
- a value with bit 7 set;
- 0xFF on the bus outside the acknowledge cycle.

Together these show sign extension, that bit 7 is ignored, and which cycle the bus is sampled in. Nine nested entries followed by nine returns expose the wrap on overflow and underflow. Returns and inhibit writes are applied both together with a request and in the middle of an entry, which shows the priority order and that the sequence is not disturbed.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  // Offset bits carried by the vector byte (a signed field)
  localparam int VEC_BITS = 7;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ENTER = 2'd1,
    ST_ACK   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int AW    = 15,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] top_o,
  output logic [$clog2(DEPTH)-1:0] ptr_o
);
  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] ptr_dec;

  // DEPTH is a power of two, so the pointer wraps naturally
  assign ptr_dec = ptr - 1'b1;
  assign top_o   = mem[ptr_dec];
  assign ptr_o   = ptr;

  // Storage has no reset, so it can map to distributed RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[ptr] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)         ptr <= '0;
    else if (push_i) ptr <= ptr + 1'b1;
    else if (pop_i)  ptr <= ptr_dec;
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic boundary_i,
  input  logic irq_i,
  input  logic inh_wr_i,
  input  logic inh_val_i,
  input  logic ret_en_i,
  input  logic ret_plain_i,
  output logic push_o,
  output logic pop_o,
  output logic vec_take_o,
  output logic ack_o,
  output logic inhibit_o,
  output logic busy_o
);
  seq_state_e state;
  logic idle, ret_any, take;

  assign idle       = (state == ST_IDLE);
  assign ret_any    = ret_en_i | ret_plain_i;
  assign pop_o      = idle & ret_any;
  assign take       = idle & ~ret_any & ~inh_wr_i & boundary_i & irq_i & ~inhibit_o;
  assign push_o     = take;
  assign vec_take_o = (state == ST_ACK);
  assign busy_o     = ~idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_o     <= 1'b0;
      inhibit_o <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (ret_any) begin
            if (ret_en_i) inhibit_o <= 1'b0;
          end else if (inh_wr_i) begin
            inhibit_o <= inh_val_i;
          end else if (take) begin
            inhibit_o <= 1'b1;
            state     <= ST_ENTER;
          end
        end
        ST_ENTER: begin
          ack_o <= 1'b1;
          state <= ST_ACK;
        end
        ST_ACK: begin
          ack_o <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW    = 15,
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary_i,
  input  logic          irq_i,
  input  logic          inh_wr_i,
  input  logic          inh_val_i,
  input  logic          ret_en_i,
  input  logic          ret_plain_i,
  input  logic [AW-1:0] cur_addr_i,
  input  logic [DW-1:0] bus_i,
  output logic          ack_o,
  output logic          inhibit_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o
);
  localparam int PW  = $clog2(DEPTH);
  localparam int EXT = AW - VEC_BITS;

  logic          push, pop, vec_take, seq_busy;
  logic [AW-1:0] stack_top;
  logic [PW-1:0] stack_ptr;
  logic [AW-1:0] vec_target;

  irq_entry_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .boundary_i  (boundary_i),
    .irq_i       (irq_i),
    .inh_wr_i    (inh_wr_i),
    .inh_val_i   (inh_val_i),
    .ret_en_i    (ret_en_i),
    .ret_plain_i (ret_plain_i),
    .push_o      (push),
    .pop_o       (pop),
    .vec_take_o  (vec_take),
    .ack_o       (ack_o),
    .inhibit_o   (inhibit_o),
    .busy_o      (seq_busy)
  );

  irq_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .pop_i   (pop),
    .wdata_i (cur_addr_i),
    .top_o   (stack_top),
    .ptr_o   (stack_ptr)
  );

  // Branch relative to zero: the offset sign-extends into the address
  assign vec_target = {{EXT{bus_i[VEC_BITS-1]}}, bus_i[VEC_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_load_o <= 1'b0;
      pc_o      <= '0;
    end else begin
      pc_load_o <= vec_take | pop;
      if (vec_take)  pc_o <= vec_target;
      else if (pop)  pc_o <= stack_top;
    end
  end
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          boundary_i,
  input logic          irq_i,
  input logic          inh_wr_i,
  input logic          ret_en_i,
  input logic          ret_plain_i,
  input logic [DW-1:0] bus_i,
  input logic          ack_o,
  input logic          inhibit_o,
  input logic          pc_load_o,
  input logic [AW-1:0] pc_o,
  input logic          seq_busy,
  input logic [PW-1:0] stack_ptr
);
  a_r4_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  a_r4_inhibit_first: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> ($past(inhibit_o) && inhibit_o));

  a_r2_accept_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_o) |-> $past(boundary_i && irq_i && !inhibit_o, 2));

  a_r5_vector_target: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> (pc_load_o &&
      pc_o == {{(AW-7){$past(bus_i[6])}}, $past(bus_i[6:0])}));

  a_r7_ret_enables: assert property (@(posedge clk) disable iff (rst)
    (ret_en_i && !seq_busy) |=> (!inhibit_o && pc_load_o));

  a_r3_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
    (!seq_busy && inhibit_o && !ret_en_i && !ret_plain_i && !inh_wr_i)
      |=> (inhibit_o && !seq_busy && $stable(stack_ptr)));

  a_r10_busy_no_pop: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && !ack_o) |=> $stable(stack_ptr));
endmodule

bind irq_entry_seq irq_entry_seq_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .boundary_i  (boundary_i),
  .irq_i       (irq_i),
  .inh_wr_i    (inh_wr_i),
  .ret_en_i    (ret_en_i),
  .ret_plain_i (ret_plain_i),
  .bus_i       (bus_i),
  .ack_o       (ack_o),
  .inhibit_o   (inhibit_o),
  .pc_load_o   (pc_load_o),
  .pc_o        (pc_o),
  .seq_busy    (seq_busy),
  .stack_ptr   (stack_ptr)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary_i = 0, irq_i = 0, inh_wr_i = 0, inh_val_i = 0;
  logic ret_en_i = 0, ret_plain_i = 0;
  logic [AW-1:0] cur_addr_i = '0;
  logic [7:0] bus_i = 8'hFF;
  logic ack_o, inhibit_o, pc_load_o;
  logic [AW-1:0] pc_o;

  irq_entry_seq uut (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .irq_i(irq_i),
    .inh_wr_i(inh_wr_i), .inh_val_i(inh_val_i), .ret_en_i(ret_en_i),
    .ret_plain_i(ret_plain_i), .cur_addr_i(cur_addr_i), .bus_i(bus_i),
    .ack_o(ack_o), .inhibit_o(inhibit_o), .pc_load_o(pc_load_o), .pc_o(pc_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit cmp_en = 0;

  // Behavioural reference model
  int exp_ack, exp_inh, exp_load, exp_pc, phase, sp;
  int stk [8];

  function automatic int sx(input int b);
    int v;
    v = b & 127;
    if (v >= 64) v = v - 128;
    return v & 32767;
  endfunction

  always @(posedge clk) begin
    cmp_en <= 1'b1;
    if (rst) begin
      exp_ack = 0; exp_inh = 0; exp_load = 0; exp_pc = 0; phase = 0; sp = 0;
    end else begin
      exp_load = 0;
      case (phase)
        0: begin
          if (ret_en_i || ret_plain_i) begin
            sp = (sp + 7) % 8;
            exp_pc = stk[sp];
            exp_load = 1;
            if (ret_en_i) exp_inh = 0;
          end else if (inh_wr_i) begin
            exp_inh = int'(inh_val_i);
          end else if (boundary_i && irq_i && exp_inh == 0) begin
            stk[sp] = int'(cur_addr_i);
            sp = (sp + 1) % 8;
            exp_inh = 1;
            phase = 1;
          end
        end
        1: begin exp_ack = 1; phase = 2; end
        default: begin
          exp_ack = 0; exp_pc = sx(int'(bus_i)); exp_load = 1; phase = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      vectors++;
      if (ack_o !== exp_ack[0] || inhibit_o !== exp_inh[0] ||
          pc_load_o !== exp_load[0] || pc_o !== exp_pc[AW-1:0]) begin
        miscompares++;
        $display("FAIL %s: ack/inh/load/pc = %0b/%0b/%0b/%h, expected %0b/%0b/%0b/%h",
                 cur_req, ack_o, inhibit_o, pc_load_o, pc_o,
                 exp_ack[0], exp_inh[0], exp_load[0], exp_pc[AW-1:0]);
      end
    end
  end

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic bnd, input logic rq, input logic wr, input logic val,
                     input logic ren, input logic rpl, input logic [AW-1:0] a,
                     input logic [7:0] b);
    @(negedge clk);
    boundary_i = bnd; irq_i = rq; inh_wr_i = wr; inh_val_i = val;
    ret_en_i = ren; ret_plain_i = rpl; cur_addr_i = a; bus_i = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, '0, 8'hFF);
  endtask

  // Accept at a boundary, then give the vector only in the acknowledge cycle
  task automatic entry(input logic [AW-1:0] a, input logic [7:0] v);
    cyc(1, 1, 0, 0, 0, 0, a, 8'hFF);
    cyc(0, 0, 0, 0, 0, 0, '0, 8'hFF);
    cyc(0, 0, 0, 0, 0, 0, '0, v);
    cyc(0, 0, 0, 0, 0, 0, '0, 8'hFF);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cur_req = "R1";
    idle(3);
    @(negedge clk);
    chk("R1", {14'd0, ack_o | inhibit_o | pc_load_o}, '0);
    chk("R1", pc_o, '0);
    rst = 1'b0;

    cur_req = "R2";
    cyc(0, 1, 0, 0, 0, 0, 15'h0111, 8'h03);
    cyc(0, 1, 0, 0, 0, 0, 15'h0111, 8'h03);
    cyc(1, 0, 0, 0, 0, 0, 15'h0111, 8'h03);
    idle(3);
    chk("R2", {14'd0, ack_o}, '0);

    cur_req = "R4 R5 R6";
    entry(15'h1234, 8'h03);
    @(negedge clk);
    chk("R5", pc_o, 15'h0003);
    chk("R4", {14'd0, inhibit_o}, 15'd1);

    cur_req = "R3";
    cyc(1, 1, 0, 0, 0, 0, 15'h0222, 8'h03);
    cyc(1, 1, 0, 0, 0, 0, 15'h0222, 8'h03);
    idle(3);
    chk("R3", {14'd0, ack_o}, '0);

    cur_req = "R8";
    cyc(0, 0, 0, 0, 0, 1, '0, 8'hFF);
    idle(1);
    @(negedge clk);
    chk("R8", pc_o, 15'h1234);
    chk("R8", {14'd0, inhibit_o}, 15'd1);

    cur_req = "R7 R5";
    cyc(0, 0, 1, 0, 0, 0, '0, 8'hFF);
    entry(15'h0456, 8'h40);
    @(negedge clk);
    chk("R5", pc_o, 15'h7FC0);
    cyc(0, 0, 0, 0, 1, 0, '0, 8'hFF);
    idle(1);
    @(negedge clk);
    chk("R7", pc_o, 15'h0456);
    chk("R7", {14'd0, inhibit_o}, '0);

    cur_req = "R9 R5";
    for (int i = 0; i < 9; i++) begin
      entry(15'h0100 + 15'(i), 8'h85);
      cyc(0, 0, 1, 0, 0, 0, '0, 8'hFF);
    end
    @(negedge clk);
    chk("R5", pc_o, 15'h0005);

    cur_req = "R10";
    cyc(1, 1, 0, 0, 0, 0, 15'h0333, 8'hFF);
    cyc(0, 0, 1, 1, 1, 1, '0, 8'hFF);
    cyc(0, 0, 1, 1, 1, 1, '0, 8'h07);
    idle(1);
    @(negedge clk);
    chk("R10", pc_o, 15'h0007);
    cyc(0, 0, 0, 0, 1, 0, '0, 8'hFF);
    cyc(1, 1, 1, 1, 1, 0, 15'h0444, 8'hFF);
    idle(2);
    @(negedge clk);
    chk("R10", {14'd0, ack_o}, '0);
    chk("R10", pc_o, 15'h0108);

    cur_req = "R9";
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 1, '0, 8'hFF);
    idle(1);
    @(negedge clk);
    chk("R9", pc_o, 15'h0108);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule